// File: doc/BRIEF.md
# Iterative Min-Sum Product Decoder

This block decodes a rate-1/2 two-dimensional product code: four information bits laid out as a 2x2 grid, protected by one parity bit per row and one per column. Soft received samples arrive serially, one signed 8-bit value per clock, with a start strobe marking the first sample of each eight-sample packet. The samples are gathered into parallel channel registers, which serve directly as channel reliabilities (the noise-variance scale is taken as one).

Every clock, two sets of extrinsic values are refreshed together. One set comes from the row checks and is fed by the latest column extrinsics. The other comes from the column checks and is fed by the latest row extrinsics. Each update uses a sign-times-minimum kernel. Start clears both sets. When the next packet's start arrives, the posteriori value of each information bit (channel plus row extrinsic plus column extrinsic) is sliced to a hard bit. The four bits are presented together with a one-cycle valid strobe.

Top module: `minsum_product_decoder`

## Requirements
- R1: While rst_n is low, and after it is released, dec_valid is 0 and y0d..y3d are 0 until the first decision is latched.
- R2: The cycle with start high carries information sample 0. The next seven cycles carry, in this order, information samples 1, 2 and 3, row parity 0 (over bits 0,1), row parity 1 (over bits 2,3), column parity 0 (over bits 0,2) and column parity 1 (over bits 1,3). Every sample is 8-bit two's complement. Output yNd is the decision for information bit N.
- R3: The extrinsic kernel returns min(|A|,|B|). Its sign is negative exactly when A and B differ in sign, and it returns zero when either input is zero.
- R4: The row extrinsic of bit i is kernel(channel of bit i^1 plus column extrinsic of bit i^1, row parity i/2).
- R5: The column extrinsic of bit i is kernel(channel of bit i^2 plus row extrinsic of bit i^2, column parity i%2). Row and column updates both happen every clock, from the registered values of the previous cycle.
- R6: In the cycle after start is sampled, every row and column extrinsic is zero.
- R7: The posteriori value of bit i is channel + row extrinsic + column extrinsic. The decision is 0 when this value is strictly positive and 1 otherwise, so a zero posteriori gives 1.
- R8: Decisions are latched, and dec_valid pulses for exactly one cycle, only on a start that arrives after all eight samples of the current packet have been received. A start that cuts a packet short produces no output. Between pulses, y0d..y3d hold their values.
- R9: Samples arriving after the eighth of a packet and before the next start, or before the first start after reset, are ignored.
- R10: Internal sums are 10-bit signed and saturating, so full-scale inputs (-128 and 127) are decoded exactly as with unbounded arithmetic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Marks the first sample of a packet |
| rxin | input | 8 | Soft received sample, two's complement |
| y0d | output | 1 | Decision for information bit 0 |
| y1d | output | 1 | Decision for information bit 1 |
| y2d | output | 1 | Decision for information bit 2 |
| y3d | output | 1 | Decision for information bit 3 |
| dec_valid | output | 1 | One-cycle strobe when y0d..y3d update |

## Verification
The decisions depend on the whole history of extrinsic exchanges since the last start. A wrong kernel sign, a swapped partner index or a missed clear therefore shows up as a wrong hard bit, but only at the next qualifying start, at least eight cycles after the fault. A capture slot written out of order corrupts the decision of the packet it belongs to. A broken packet counter shows up as a missing, extra or misplaced dec_valid pulse. Comparing the bench's cycle-stepped model every cycle catches each of these as soon as it reaches the ports.

// File: rtl/pdec_pkg.sv
package pdec_pkg;

  parameter int SAMPLE_W  = 8;
  parameter int SUM_W     = SAMPLE_W + 2;
  parameter int N_SAMPLES = 8;
  parameter int N_INFO    = 4;
  parameter int CNT_W     = $clog2(N_SAMPLES + 1);
  parameter int ROW_BASE  = N_INFO;
  parameter int COL_BASE  = N_INFO + N_INFO / 2;

  typedef logic signed [SAMPLE_W-1:0] smp_t;
  typedef logic signed [SUM_W-1:0]    llr_t;

  localparam llr_t LLR_MAX = {1'b0, {(SUM_W-1){1'b1}}};
  localparam llr_t LLR_MIN = {1'b1, {(SUM_W-1){1'b0}}};

  // sign-extend a channel sample to the internal width
  function automatic llr_t widen(smp_t s);
    return llr_t'(s);
  endfunction

  // saturating signed addition at the internal width
  function automatic llr_t sat_add(llr_t a, llr_t b);
    logic [SUM_W:0] s;
    s = {a[SUM_W-1], a} + {b[SUM_W-1], b};
    if (s[SUM_W] != s[SUM_W-1])
      return s[SUM_W] ? LLR_MIN : LLR_MAX;
    return s[SUM_W-1:0];
  endfunction

  // magnitude with one extra bit so the most negative value is exact
  function automatic logic [SUM_W:0] mag_of(llr_t a);
    logic [SUM_W:0] ext;
    ext = {a[SUM_W-1], a};
    return a[SUM_W-1] ? (~ext + 1'b1) : ext;
  endfunction

  // sign(A*B) * min(|A|,|B|)
  function automatic llr_t ext_kernel(llr_t a, llr_t b);
    logic [SUM_W:0] ma, mb, m, nm;
    logic           neg;
    ma  = mag_of(a);
    mb  = mag_of(b);
    m   = (ma < mb) ? ma : mb;
    if (m > {2'b00, {(SUM_W-1){1'b1}}})
      m = {2'b00, {(SUM_W-1){1'b1}}};
    neg = a[SUM_W-1] ^ b[SUM_W-1];
    nm  = ~m + 1'b1;
    return neg ? nm[SUM_W-1:0] : m[SUM_W-1:0];
  endfunction

  // decision: 0 when strictly positive, else 1
  function automatic logic hard_bit(llr_t p);
    return p[SUM_W-1] || (p == '0);
  endfunction

endpackage

// File: rtl/pdec_sampler.sv
module pdec_sampler
  import pdec_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [SAMPLE_W-1:0] rxin,
  output smp_t                chan [N_SAMPLES],
  output logic                full
);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] wr_idx;
  logic             mid_packet;
  logic             wr_any;
  smp_t             slots [N_SAMPLES];

  assign mid_packet = (cnt != '0) && (cnt < CNT_W'(N_SAMPLES));
  assign wr_any     = start | mid_packet;
  assign wr_idx     = start ? '0 : cnt;
  assign full       = (cnt == CNT_W'(N_SAMPLES));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (start)      cnt <= CNT_W'(1);
    else if (mid_packet) cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < N_SAMPLES; k++) slots[k] <= '0;
    end else begin
      for (int k = 0; k < N_SAMPLES; k++)
        if (wr_any && (wr_idx == CNT_W'(k))) slots[k] <= smp_t'(rxin);
    end
  end

  assign chan = slots;

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(N_SAMPLES)); // R2

  AST_SLOT0_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> ($unsigned(slots[0]) == $past(rxin))); // R2

  for (genvar k = 0; k < N_SAMPLES; k++) begin : g_freeze
    AST_FULL_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      (full && !start) |=> $stable(slots[k])); // R9
    AST_IDLE_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      ((cnt == '0) && !start) |=> $stable(slots[k])); // R9
  end

endmodule

// File: rtl/pdec_iter_core.sv
module pdec_iter_core
  import pdec_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  smp_t chan    [N_SAMPLES],
  output llr_t row_ext [N_INFO],
  output llr_t col_ext [N_INFO]
);

  llr_t row_in  [N_INFO];
  llr_t row_nxt [N_INFO];
  llr_t col_in  [N_INFO];
  llr_t col_nxt [N_INFO];
  llr_t row_q   [N_INFO];
  llr_t col_q   [N_INFO];

  for (genvar i = 0; i < N_INFO; i++) begin : g_bit
    localparam int ROW_MATE = i ^ 1;
    localparam int ROW_PAR  = ROW_BASE + i / 2;
    localparam int COL_MATE = i ^ 2;
    localparam int COL_PAR  = COL_BASE + i % 2;

    // row check, fed by the latest column extrinsic of the row mate
    assign row_in[i]  = sat_add(widen(chan[ROW_MATE]), col_q[ROW_MATE]);
    assign row_nxt[i] = ext_kernel(row_in[i], widen(chan[ROW_PAR]));

    // column check, fed by the latest row extrinsic of the column mate
    assign col_in[i]  = sat_add(widen(chan[COL_MATE]), row_q[COL_MATE]);
    assign col_nxt[i] = ext_kernel(col_in[i], widen(chan[COL_PAR]));

    AST_ROW_MAG: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(clear) |-> (mag_of(row_q[i]) <= mag_of(widen($past(chan[ROW_PAR]))))); // R3
    AST_COL_MAG: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(clear) |-> (mag_of(col_q[i]) <= mag_of(widen($past(chan[COL_PAR]))))); // R3
    AST_ROW_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
      (row_q[i] != '0) |-> (row_q[i][SUM_W-1] ==
        ($past(row_in[i][SUM_W-1]) ^ $past(chan[ROW_PAR][SAMPLE_W-1])))); // R4
    AST_COL_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
      (col_q[i] != '0) |-> (col_q[i][SUM_W-1] ==
        ($past(col_in[i][SUM_W-1]) ^ $past(chan[COL_PAR][SAMPLE_W-1])))); // R5
    AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> ((row_q[i] == '0) && (col_q[i] == '0))); // R6
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_INFO; i++) begin
        row_q[i] <= '0;
        col_q[i] <= '0;
      end
    end else if (clear) begin
      for (int i = 0; i < N_INFO; i++) begin
        row_q[i] <= '0;
        col_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < N_INFO; i++) begin
        row_q[i] <= row_nxt[i];
        col_q[i] <= col_nxt[i];
      end
    end
  end

  assign row_ext = row_q;
  assign col_ext = col_q;

endmodule

// File: rtl/pdec_decide.sv
module pdec_decide
  import pdec_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              full,
  input  smp_t              info_ch [N_INFO],
  input  llr_t              row_ext [N_INFO],
  input  llr_t              col_ext [N_INFO],
  output logic [N_INFO-1:0] yd,
  output logic              valid
);

  llr_t              post [N_INFO];
  logic [N_INFO-1:0] hard;
  logic              fire;

  for (genvar i = 0; i < N_INFO; i++) begin : g_post
    assign post[i] = sat_add(sat_add(widen(info_ch[i]), row_ext[i]), col_ext[i]);
    assign hard[i] = hard_bit(post[i]);

    AST_ZERO_IS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && (post[i] == '0)) |=> yd[i]); // R7
    AST_POS_IS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && !post[i][SUM_W-1] && (post[i] != '0)) |=> !yd[i]); // R7
  end

  assign fire = start & full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      yd    <= '0;
    end else begin
      valid <= fire;
      if (fire) yd <= hard;
    end
  end

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> !valid); // R8
  AST_VALID_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> $past(start)); // R8
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |-> $stable(yd)); // R8

endmodule

// File: rtl/minsum_product_decoder.sv
module minsum_product_decoder
  import pdec_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [SAMPLE_W-1:0] rxin,
  output logic                y0d,
  output logic                y1d,
  output logic                y2d,
  output logic                y3d,
  output logic                dec_valid
);

  smp_t              chan    [N_SAMPLES];
  smp_t              info_ch [N_INFO];
  llr_t              row_ext [N_INFO];
  llr_t              col_ext [N_INFO];
  logic              full;
  logic [N_INFO-1:0] yd;

  pdec_sampler u_sampler (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .rxin  (rxin),
    .chan  (chan),
    .full  (full)
  );

  pdec_iter_core u_core (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (start),
    .chan    (chan),
    .row_ext (row_ext),
    .col_ext (col_ext)
  );

  for (genvar i = 0; i < N_INFO; i++) begin : g_info
    assign info_ch[i] = chan[i];
  end

  pdec_decide u_decide (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .full    (full),
    .info_ch (info_ch),
    .row_ext (row_ext),
    .col_ext (col_ext),
    .yd      (yd),
    .valid   (dec_valid)
  );

  assign y0d = yd[0];
  assign y1d = yd[1];
  assign y2d = yd[2];
  assign y3d = yd[3];

endmodule

// File: tb/tb_minsum_product_decoder.sv
`timescale 1ns/1ps
module tb_minsum_product_decoder;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [7:0] rxin = '0;
  logic       y0d, y1d, y2d, y3d, dec_valid;

  always #2 clk = ~clk;

  minsum_product_decoder dut (
    .clk(clk), .rst_n(rst_n), .start(start), .rxin(rxin),
    .y0d(y0d), .y1d(y1d), .y2d(y2d), .y3d(y3d), .dec_valid(dec_valid)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // reference model state
  int       m_ch [8];
  int       m_er [4];
  int       m_ec [4];
  int       m_cnt;
  bit       exp_valid;
  bit [3:0] exp_y;

  // second-level check on decoded data
  bit       ideal_on;
  bit [3:0] ideal_nib;
  string    ideal_tag;
  int       pkt [8];

  // {data, replaced position (8 = none), wrong-sign magnitude, gap}
  localparam logic [23:0] VEC [8] = '{
    {4'h0, 4'd8, 8'd0,  8'd10},
    {4'h5, 4'd0, 8'd10, 8'd10},
    {4'hA, 4'd3, 8'd20, 8'd10},
    {4'hF, 4'd4, 8'd12, 8'd10},
    {4'h9, 4'd6, 8'd25, 8'd10},
    {4'h6, 4'd1, 8'd5,  8'd12},
    {4'h3, 4'd2, 8'd18, 8'd10},
    {4'hC, 4'd7, 8'd30, 8'd10}
  };

  function automatic int kern(int a, int b);
    int ma, mb, m;
    ma = (a < 0) ? -a : a;
    mb = (b < 0) ? -b : b;
    m  = (ma < mb) ? ma : mb;
    return ((a < 0) != (b < 0)) ? -m : m;
  endfunction

  task automatic model_reset();
    for (int k = 0; k < 8; k++) m_ch[k] = 0;
    for (int i = 0; i < 4; i++) begin m_er[i] = 0; m_ec[i] = 0; end
    m_cnt = 0; exp_valid = 0; exp_y = '0;
  endtask

  task automatic model_advance(bit s, int rx);
    int ner [4];
    int nec [4];
    if (s && m_cnt == 8) begin
      exp_valid = 1;
      for (int i = 0; i < 4; i++) exp_y[i] = (m_ch[i] + m_er[i] + m_ec[i]) <= 0;
    end else begin
      exp_valid = 0;
    end
    for (int i = 0; i < 4; i++) begin
      ner[i] = s ? 0 : kern(m_ch[i ^ 1] + m_ec[i ^ 1], m_ch[4 + i / 2]);
      nec[i] = s ? 0 : kern(m_ch[i ^ 2] + m_er[i ^ 2], m_ch[6 + i % 2]);
    end
    for (int i = 0; i < 4; i++) begin m_er[i] = ner[i]; m_ec[i] = nec[i]; end
    if (s) begin
      m_ch[0] = rx; m_cnt = 1;
    end else if (m_cnt != 0 && m_cnt < 8) begin
      m_ch[m_cnt] = rx; m_cnt++;
    end
  endtask

  // called at a falling edge; returns at the next falling edge after checking
  task automatic step(bit s, int rx);
    bit [3:0] got;
    start = s;
    rxin  = rx[7:0];
    model_advance(s, rx);
    @(negedge clk);
    got = {y3d, y2d, y1d, y0d};
    checks++;
    if (dec_valid !== exp_valid) begin
      errors++;
      $display("FAIL R8 dec_valid: actual %0b expected %0b", dec_valid, exp_valid);
    end
    checks++;
    if (got !== exp_y) begin
      errors++;
      $display("FAIL R7 decisions: actual %b expected %b", got, exp_y);
    end
    if (exp_valid && ideal_on) begin
      checks++;
      if (got !== ideal_nib) begin
        errors++;
        $display("FAIL %s decoded data: actual %b expected %b", ideal_tag, got, ideal_nib);
      end
      ideal_on = 0;
    end
  endtask

  task automatic make_packet(bit [3:0] d, int pos, int nz);
    bit b [8];
    for (int i = 0; i < 4; i++) b[i] = d[i];
    b[4] = d[0] ^ d[1];
    b[5] = d[2] ^ d[3];
    b[6] = d[0] ^ d[2];
    b[7] = d[1] ^ d[3];
    for (int k = 0; k < 8; k++) pkt[k] = b[k] ? -32 : 32;
    if (pos < 8) pkt[pos] = b[pos] ? nz : -nz;
  endtask

  task automatic send_packet(int gap, bit junk);
    for (int k = 0; k < 8; k++) step(k == 0, pkt[k]);
    for (int g = 0; g < gap; g++) step(1'b0, junk ? ((g * 37) % 200) - 100 : 0);
  endtask

  task automatic check_idle(string what);
    checks++;
    if (dec_valid !== 1'b0 || {y3d, y2d, y1d, y0d} !== 4'b0) begin
      errors++;
      $display("FAIL R1 %s: actual valid=%0b y=%b expected valid=0 y=0000",
               what, dec_valid, {y3d, y2d, y1d, y0d});
    end
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    model_reset();
    ideal_on = 0;
    repeat (3) @(negedge clk);
    check_idle("in reset");                          // R1
    rst_n = 1'b1;
    @(negedge clk);
    check_idle("after release");                     // R1

    // R9: samples before any start are ignored
    for (int g = 0; g < 5; g++) step(1'b0, 77 - g * 40);

    // table walk: R2 R3 R4 R5 R9 (junk in every gap)
    foreach (VEC[e]) begin
      make_packet(VEC[e][23:20], int'(VEC[e][19:16]), int'(VEC[e][15:8]));
      send_packet(int'(VEC[e][7:0]), 1'b1);
      ideal_nib = VEC[e][23:20];
      ideal_tag = "R2 R3 R4 R5 R9";
      ideal_on  = 1;
    end

    // R7: all-zero samples give zero posteriori, decided as 1
    for (int k = 0; k < 8; k++) pkt[k] = 0;
    send_packet(8, 1'b0);
    ideal_nib = 4'hF; ideal_tag = "R7"; ideal_on = 1;

    // R10: full-scale codeword, bits 1,0,1,0
    pkt = '{-128, 127, -128, 127, -128, -128, 127, 127};
    send_packet(8, 1'b0);
    ideal_nib = 4'b0101; ideal_tag = "R10"; ideal_on = 1;

    // R10: inconsistent full-scale extremes, model comparison only
    pkt = '{-128, -128, -128, -128, -128, -128, -128, -128};
    send_packet(6, 1'b0);
    pkt = '{127, -128, 127, 127, -128, 127, -128, 127};
    send_packet(6, 1'b0);

    // R8: back-to-back packets with no gap
    make_packet(4'h3, 0, 9);
    send_packet(0, 1'b0);
    make_packet(4'hE, 5, 14);
    send_packet(0, 1'b0);

    // R8: start cutting a packet short gives no pulse
    make_packet(4'h7, 8, 0);
    for (int k = 0; k < 4; k++) step(k == 0, pkt[k]);
    make_packet(4'h2, 8, 0);
    send_packet(9, 1'b1);
    ideal_nib = 4'h2; ideal_tag = "R8"; ideal_on = 1;
    step(1'b1, 32);
    for (int g = 0; g < 3; g++) step(1'b0, 32);

    // R1: reset in the middle of a packet
    rst_n = 1'b0;
    model_reset();
    @(negedge clk);
    check_idle("mid-run reset");
    rst_n = 1'b1;
    step(1'b1, 20);
    step(1'b0, 20);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule